// File: doc/BRIEF.md
# ADC Calibration Sequencer and Output Gating

This block is the digital reset and calibration controller of a pipelined data converter. It combines an active-low external reset with analog and digital supply-good flags into one internal reset. That reset asserts at once and releases in step with the conversion clock. When reset releases, a timed self-calibration run starts. A cycle counter with a parameterised terminal count sets how long the run lasts. A one-bit done flag reports the end of the run, and software reads it through a small register port.

Until calibration finishes, the 16-bit output bus carries a fixed marker word (0xCCCC) instead of conversion data. Once calibration is done, the bus carries raw 14-bit samples. Each sample passes through a fixed-depth delay line that models the converter's conversion latency, and it sits left-aligned on the bus. The forwarded output clock is held low while reset is asserted. It starts following the input clock at the first rising edge after release.

Top module: `adc_cal_seq`

## Requirements
- R1: The internal reset is active whenever `ext_rst_n`, `avdd_ok` or `dvdd_ok` is low. It asserts asynchronously and releases through a two-flop synchroniser on `clk`. While it is active, status reads are ignored and `data_out` shows the marker.
- R2: Let `clk` edge 1 be the first rising edge after all three reset inputs are high. `cal_done` rises at rising edge CAL_CYCLES+3. Until then `data_out` is 0xCCCC, and from that edge on `data_out` carries pipeline data.
- R3: A read with `rd_en` high at address 0xB6 returns `cal_done` in bit 0, with bits 7:1 zero. `rd_data` shows the result after the rising edge that samples `rd_en`. Once set, `cal_done` stays set until reset.
- R4: While `cal_done` is 0, `data_out` equals 0xCCCC on all 16 bits.
- R5: While any reset input is low, `clk_out` is low. From the first rising edge of `clk` after release, `clk_out` follows `clk`.
- R6: After calibration, `data_out[15:2]` holds the `sample_in` value captured nine rising edges earlier, so each sample passes through ten register stages. `data_out[1:0]` is 0.
- R7: A read that is sampled while the synchronised internal reset is still low returns `rd_data` = 0 with `rd_ignored` = 1 for one cycle. The second rising edge after release still counts as reset.
- R8: A read of any address other than 0xB6, outside reset, returns 0 with `rd_ignored` = 0.
- R9: Asserting reset during calibration aborts the run and clears `cal_done` at once. The next release starts a full new run of CAL_CYCLES+3 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| ext_rst_n | input | 1 | External reset, active low |
| avdd_ok | input | 1 | Analog supply above threshold |
| dvdd_ok | input | 1 | Digital supply above threshold |
| sample_in | input | 14 | Raw conversion result |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read result, one cycle after the strobe |
| rd_ignored | output | 1 | Read was dropped because reset was active |
| data_out | output | 16 | Output data bus, marker or delayed sample |
| clk_out | output | 1 | Forwarded output clock, gated during reset |

## Verification
The bench builds the block with CAL_CYCLES = 200 and the default latency of ten stages and 14-bit samples. With this short terminal count, a complete calibration run takes about two hundred cycles. That makes the exact completion edge, an aborted run followed by a full restart, and a latency walk over a table of sample words all reachable in one short run. The rest of the datapath is checked at its production widths.

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int SAMPLE_W   = 14,
  parameter int BUS_W      = 16,
  parameter int LATENCY    = 10,
  parameter int CAL_CYCLES = 70_000_000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hB6,
  parameter logic [BUS_W-1:0]  MARKER      = 16'hCCCC
) (
  input  logic                clk,
  input  logic                ext_rst_n,
  input  logic                avdd_ok,
  input  logic                dvdd_ok,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_ignored,
  output logic [BUS_W-1:0]    data_out,
  output logic                clk_out
);
  localparam int CNT_W = $clog2(CAL_CYCLES + 1);
  localparam int PAD_W = BUS_W - SAMPLE_W;

  logic             rst_raw_n;
  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic             rst_d;
  logic             cal_done;
  logic             clk_en;
  logic [CNT_W-1:0] cal_cnt;
  logic [SAMPLE_W-1:0] pipe [LATENCY];

  assign rst_raw_n = ext_rst_n & avdd_ok & dvdd_ok;
  assign rst_n_s   = rst_sync[1];

  always_ff @(posedge clk or negedge rst_raw_n) begin
    if (!rst_raw_n) begin
      rst_sync <= '0;
      rst_d    <= 1'b0;
      clk_en   <= 1'b0;
      cal_cnt  <= '0;
      cal_done <= 1'b0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
      rst_d    <= rst_n_s;
      clk_en   <= 1'b1;
      if (rst_d && !cal_done) begin
        if (cal_cnt == CNT_W'(CAL_CYCLES - 1)) cal_done <= 1'b1;
        else                                   cal_cnt  <= cal_cnt + 1'b1;
      end
    end
  end

  assign clk_out = clk & clk_en;

  always_ff @(posedge clk) begin
    pipe[0] <= sample_in;
    for (int i = 1; i < LATENCY; i++) pipe[i] <= pipe[i-1];
  end

  assign data_out = cal_done ? {pipe[LATENCY-1], {PAD_W{1'b0}}} : MARKER;

  always_ff @(posedge clk) begin
    rd_ignored <= 1'b0;
    rd_data    <= '0;
    if (rd_en) begin
      if (!rst_n_s)                    rd_ignored <= 1'b1;
      else if (rd_addr == STATUS_ADDR) rd_data    <= DATA_W'(cal_done);
    end
  end
endmodule

module adc_cal_seq_chk #(
  parameter int SAMPLE_W = 14,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hB6,
  parameter logic [BUS_W-1:0]  MARKER      = 16'hCCCC
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              cal_done,
  input logic [BUS_W-1:0]  data_out,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_ignored
);
  localparam int PAD_W = BUS_W - SAMPLE_W;

  // R4
  marker_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cal_done |-> data_out == MARKER);

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cal_done |=> cal_done);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n_s |-> !cal_done);

  // R6
  left_align_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cal_done |-> data_out[PAD_W-1:0] == '0);

  // R7
  ignored_zero_chk: assert property (@(posedge clk)
    rd_ignored |-> rd_data == '0);

  // R3
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rd_en) && $past(rst_n_s) && $past(rd_addr) == STATUS_ADDR
      |-> rd_data == DATA_W'($past(cal_done)) && !rd_ignored);

  // R8
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rd_en) && $past(rst_n_s) && $past(rd_addr) != STATUS_ADDR
      |-> rd_data == '0 && !rd_ignored);
endmodule

bind adc_cal_seq adc_cal_seq_chk #(
  .SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STATUS_ADDR(STATUS_ADDR), .MARKER(MARKER)
) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .cal_done(cal_done), .data_out(data_out),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ignored(rd_ignored)
);

// File: tb/adc_cal_seq_tb_top.sv
module adc_cal_seq_tb_top;
  localparam int N = 200;
  localparam logic [15:0] MARK = 16'hCCCC;
  localparam logic [13:0] VEC [20] = '{
    14'h3FFF, 14'h0000, 14'h3333, 14'h0001, 14'h2000, 14'h1555, 14'h2AAA,
    14'h0F0F, 14'h30C3, 14'h0123, 14'h3210, 14'h1FFF, 14'h2001, 14'h0ABC,
    14'h3CCC, 14'h0008, 14'h1234, 14'h3E01, 14'h0777, 14'h2468};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        ext_rst_n, avdd_ok, dvdd_ok, rd_en, rd_ignored, clk_out;
  logic [13:0] sample_in;
  logic [7:0]  rd_addr, rd_data;
  logic [15:0] data_out;

  adc_cal_seq #(.CAL_CYCLES(N)) dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .avdd_ok(avdd_ok), .dvdd_ok(dvdd_ok),
    .sample_in(sample_in), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ignored(rd_ignored), .data_out(data_out),
    .clk_out(clk_out));

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [7:0] addr, int unsigned exp_d, int unsigned exp_i, string req);
    rd_en = 1'b1;
    rd_addr = addr;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " rd_data"}, 32'(rd_data), exp_d);
    chk({req, " rd_ignored"}, 32'(rd_ignored), exp_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ext_rst_n = 1'b0; avdd_ok = 1'b0; dvdd_ok = 1'b0;
    sample_in = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R4 marker in reset", 32'(data_out), 32'(MARK));
    @(posedge clk); #2;
    chk("R5 clk_out low in reset", 32'(clk_out), 0);
    @(negedge clk);
    do_read(8'hB6, 0, 1, "R7");

    // R1: one supply flag low keeps reset active
    ext_rst_n = 1'b1; avdd_ok = 1'b1;
    repeat (20) @(negedge clk);
    do_read(8'hB6, 0, 1, "R1 dvdd low");
    chk("R1 marker", 32'(data_out), 32'(MARK));
    avdd_ok = 1'b0; dvdd_ok = 1'b1;
    repeat (20) @(negedge clk);
    do_read(8'hB6, 0, 1, "R1 avdd low");

    // release: next rising edge is edge 1
    avdd_ok = 1'b1;
    @(posedge clk); #2;
    chk("R5 clk_out resumes", 32'(clk_out), 1);
    @(negedge clk);
    do_read(8'hB6, 0, 1, "R7 edge2");
    do_read(8'hB6, 0, 0, "R3 busy");
    do_read(8'h10, 0, 0, "R8");
    repeat (N - 2) @(posedge clk);
    @(negedge clk);
    chk("R2 marker before done", 32'(data_out), 32'(MARK));
    @(posedge clk);
    @(negedge clk);
    chk("R2 data at done", 32'(data_out), 0);
    do_read(8'hB6, 1, 0, "R3 done");
    do_read(8'hB7, 0, 0, "R8 neighbour");

    // R6: latency walk over the table
    for (int i = 0; i < 20; i++) begin
      sample_in = VEC[i];
      @(posedge clk);
      @(negedge clk);
      if (i >= 9) chk("R6 latency", 32'(data_out), 32'({VEC[i-9], 2'b00}));
      else        chk("R6 latency", 32'(data_out), 0);
    end
    sample_in = '0;

    // R9: reset during calibration aborts
    ext_rst_n = 1'b0;
    #1;
    chk("R9 marker on reset", 32'(data_out), 32'(MARK));
    @(posedge clk); #2;
    chk("R5 clk_out gated again", 32'(clk_out), 0);
    @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R9 marker mid run", 32'(data_out), 32'(MARK));
    ext_rst_n = 1'b0;
    @(negedge clk);
    do_read(8'hB6, 0, 1, "R9 status in reset");
    ext_rst_n = 1'b1;
    repeat (N + 2) @(posedge clk);
    @(negedge clk);
    chk("R9 full restart marker", 32'(data_out), 32'(MARK));
    @(posedge clk);
    @(negedge clk);
    chk("R9 restart done", 32'(data_out), 0);
    do_read(8'hB6, 1, 0, "R3 after restart");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule